// File: doc/BRIEF.md
# Asynchronous Serial Port with Selectable Bit Clock

This block is a full-duplex asynchronous serial port. A transmitter and a receiver run on their own and at the same time. Each has a one-byte holding register in front of its shift register. Software can therefore load the next byte while the current one is still leaving the line, and it can read a received byte while the next one is arriving. A character starts with a low start bit. Then come 7 or 8 data bits, least significant bit first, then an optional parity bit, and then one or two high stop bits.

The bit timing comes from a 16x oversampling tick, and this tick has two possible sources. The first is an internal divider on the system clock. In that case the clock pin can stay unused, or it can drive out a clock at the bit rate. The second is an external clock pin that carries 16 times the bit rate. In that case the pin is an input. That input is synchronised with two flops and its rising edges are detected. The system clock must be at least four times faster than this external clock.

Software uses a small register port with four addresses: frame and clock control, divisor, data, and status.

Top module: `async_port`

## Requirements
- R1: After reset, and whenever no character is being sent, `txd` is high. Every start bit begins from the high level.
- R2: Control bit 5 (0 = 8 data bits, 1 = 7 data bits) sets the data length. Writing address 2 queues a byte. It is sent as a low start bit followed by its data bits, least significant bit first. Each bit lasts 16 ticks. The receiver returns the same data bits at address 2, with bit 7 read as zero in 7-bit mode.
- R3: Control bit 2 enables a parity bit after the data. Control bit 3 selects the sense: 0 makes the count of ones in data plus parity even, and 1 makes it odd.
- R4: Control bit 4 selects one stop bit (0) or two stop bits (1). A byte that is already held starts right after the last stop bit of the current character, with no idle gap. Successive start bits are therefore exactly (1 + data + parity + stop) × 16 ticks apart.
- R5: Status bit 0 (transmit empty) is 1 when the holding register can take a byte. Status bit 1 (transmit end) is 1 when the shifter is idle and nothing is pending. Both are 1 after reset. A write to address 2 while the holding register is full is ignored.
- R6: With control bit 1 = 0, the tick comes every (divisor+1) system clocks, where the divisor is at address 1. With control bit 0 = 1, `sck_oe` is 1 and `sck_out` is a bit-rate clock that is high for 8 ticks and low for 8 ticks. With control bit 0 = 0, `sck_oe` is 0.
- R7: With control bit 1 = 1, each rising edge of `sck_in` is one tick, and `sck_oe` is 0.
- R8: The receiver checks the start bit again at sample 8 of that bit. A low pulse shorter than half a bit does not deliver a character.
- R9: Status bit 2 (receive full) is set when a character completes. Reading address 2 returns the byte and clears the flag. If a character completes while the flag is still set, status bit 3 (overrun) is set and the old byte is kept.
- R10: Status bit 4 is set when the first stop bit samples low (framing error). Status bit 5 is set when the received parity does not match (parity error). The byte is still delivered in both cases.
- R11: Writing address 3 clears each of status bits 3 to 5 whose position holds a 1 in the write data.
- R12: If a read of address 2 falls in the same cycle as the completion of a new character, the read returns the old byte. The new byte is then stored, receive-full stays set, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 2 pops the receive byte) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| sck_in | input | 1 | External 16x clock |
| sck_out | output | 1 | Bit-rate clock output |
| sck_oe | output | 1 | Drive enable for the clock pin |

## Verification
Two events can land in the same cycle: software popping the receive buffer, and the receiver storing a newly completed character. The bench first sends one character with the buffer empty and measures how many cycles pass from its first start-bit edge until receive-full rises. It then sends a second character at the same tick phase and schedules the read of address 2 for exactly the edge where that character is stored. The result is correct when the read returns the first byte, overrun stays clear, receive-full stays set, and the next read returns the second byte.

// File: rtl/aport_pkg.sv
package aport_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic len7;
    logic two_stop;
    logic par_odd;
    logic par_en;
    logic ext_clk;
    logic pin_out;
  } cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } fstate_t;

  // parity bit over the active data bits; odd selects odd total
  function automatic logic par_bit(logic [DATA_W-1:0] d, logic len7, logic odd);
    logic [DATA_W-1:0] m;
    m = d;
    if (len7) m[DATA_W-1] = 1'b0;
    return (^m) ^ odd;
  endfunction

  // right-justify the receive shifter when fewer bits were shifted in
  function automatic logic [DATA_W-1:0] align_rx(logic [DATA_W-1:0] sh, logic len7);
    return len7 ? {1'b0, sh[DATA_W-1:1]} : sh;
  endfunction
endpackage

// File: rtl/aport_baud.sv
module aport_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             pin_out,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sck_in,
  output logic             tick,
  output logic             sck_out,
  output logic             sck_oe
);
  localparam int HALF   = OVS / 2;
  localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DIV_W-1:0]  cnt;
  logic              tick_int, tick_ext;
  logic              sy1, sy2, sy3;
  logic [HALF_W-1:0] hcnt;
  logic              pin_q;

  assign tick_int = (cnt == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (ext_sel)  cnt <= '0;
    else if (tick_int) cnt <= '0;
    else               cnt <= cnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b0; sy2 <= 1'b0; sy3 <= 1'b0;
    end else begin
      sy1 <= sck_in; sy2 <= sy1; sy3 <= sy2;
    end
  end
  assign tick_ext = sy2 & ~sy3;

  assign tick = ext_sel ? tick_ext : tick_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      pin_q <= 1'b0;
    end else if (tick) begin
      if (hcnt == HALF_W'(HALF - 1)) begin
        hcnt  <= '0;
        pin_q <= ~pin_q;
      end else begin
        hcnt <= hcnt + HALF_W'(1);
      end
    end
  end

  assign sck_oe  = pin_out & ~ext_sel;
  assign sck_out = sck_oe & pin_q;

  // R6: with a nonzero divisor the internal tick never fires two cycles running
  p_int_tick_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && tick_int && divisor != '0) |=> (!tick_int || divisor == '0));
endmodule

// File: rtl/aport_tx.sv
module aport_tx import aport_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              len7,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_end
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  fstate_t           state;
  logic [SUB_W-1:0]  sub;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [DATA_W-1:0] hold, shreg;
  logic              hold_v, pbit, stopn;
  logic              bit_end, frame_done, take;

  assign last_idx   = len7 ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
  assign bit_end    = tick && (sub == SUB_LAST);
  assign frame_done = (state == ST_STOP) && bit_end && (stopn == two_stop);
  assign take       = hold_v && tick && ((state == ST_IDLE) || frame_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      hold_v <= 1'b0;
    end else if (take) begin
      hold_v <= 1'b0;
    end else if (wr && !hold_v) begin
      hold   <= wdata;
      hold_v <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sub   <= '0;
      idx   <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
      stopn <= 1'b0;
    end else begin
      if (state != ST_IDLE && tick)
        sub <= (sub == SUB_LAST) ? '0 : sub + SUB_W'(1);
      if (take) begin
        state <= ST_START;
        sub   <= '0;
        shreg <= hold;
        pbit  <= par_bit(hold, len7, par_odd);
      end else if (bit_end) begin
        unique case (state)
          ST_START: begin
            state <= ST_DATA;
            idx   <= '0;
          end
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (idx == last_idx) begin
              state <= par_en ? ST_PAR : ST_STOP;
              stopn <= 1'b0;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
          ST_PAR: begin
            state <= ST_STOP;
            stopn <= 1'b0;
          end
          ST_STOP: begin
            if (stopn != two_stop) stopn <= 1'b1;
            else                   state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = pbit;
      default:  txd = 1'b1;
    endcase
  end

  assign tx_empty = ~hold_v;
  assign tx_end   = (state == ST_IDLE) && ~hold_v;

  // R1: every start bit is entered from the mark level
  p_start_from_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && $past(state) != ST_START) |-> $past(txd));
  // R5: transmit end can only be reported with an empty holding register
  p_end_implies_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> tx_empty);
  // R5: a write into a full holding register leaves the pending byte alone
  p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && wr && !take) |=> (hold == $past(hold)));
endmodule

// File: rtl/aport_rx.sv
module aport_rx import aport_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              len7,
  input  logic              pop,
  input  logic [2:0]        clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr,
  output logic              ferr,
  output logic              perr
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  fstate_t           state;
  logic [SUB_W-1:0]  sub;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [DATA_W-1:0] shreg, got;
  logic              sy1, line, prx;
  logic              mid_pt, bit_end;
  logic              abort_evt, store_evt, ovr_set, ferr_set, perr_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1  <= 1'b1;
      line <= 1'b1;
    end else begin
      sy1  <= rxd;
      line <= sy1;
    end
  end

  assign last_idx  = len7 ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);
  assign mid_pt    = tick && (sub == SUB_MID);
  assign bit_end   = tick && (sub == SUB_LAST);
  assign abort_evt = (state == ST_START) && mid_pt && line;
  assign store_evt = (state == ST_STOP) && mid_pt;
  assign got       = align_rx(shreg, len7);
  assign ovr_set   = store_evt && rx_full && !pop;
  assign ferr_set  = store_evt && !line;
  assign perr_set  = store_evt && par_en && (prx != par_bit(got, len7, par_odd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sub   <= '0;
      idx   <= '0;
      shreg <= '0;
      prx   <= 1'b0;
    end else begin
      if (state != ST_IDLE && tick)
        sub <= (sub == SUB_LAST) ? '0 : sub + SUB_W'(1);
      unique case (state)
        ST_IDLE: if (!line) begin
          state <= ST_START;
          sub   <= '0;
        end
        ST_START: begin
          if (abort_evt) state <= ST_IDLE;
          else if (bit_end) begin
            state <= ST_DATA;
            idx   <= '0;
          end
        end
        ST_DATA: begin
          if (mid_pt) shreg <= {line, shreg[DATA_W-1:1]};
          if (bit_end) begin
            if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
            else                 idx   <= idx + IDX_W'(1);
          end
        end
        ST_PAR: begin
          if (mid_pt)  prx   <= line;
          if (bit_end) state <= ST_STOP;
        end
        ST_STOP: if (store_evt) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
    end else if (store_evt) begin
      if (!rx_full || pop) begin
        rx_data <= got;
        rx_full <= 1'b1;
      end
    end else if (pop) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr  <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
    end else begin
      ovr  <= (ovr  & ~clr[0]) | ovr_set;
      ferr <= (ferr & ~clr[1]) | ferr_set;
      perr <= (perr & ~clr[2]) | perr_set;
    end
  end

  // R9: a completion into a full, unread buffer keeps the old byte and flags it
  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && rx_full && !pop) |=> (rx_data == $past(rx_data)) && ovr);
  // R9: every completed character leaves the buffer full
  p_store_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> rx_full);
  // R12: a pop coinciding with a store never raises overrun
  p_collide_no_ovr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && pop && !ovr && !clr[0]) |=> !ovr);
  // R8: an aborted start returns the receiver to idle
  p_abort_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (state == ST_IDLE));
endmodule

// File: rtl/async_port.sv
module async_port import aport_pkg::*; #(
  parameter int               DIV_W   = 8,
  parameter int               OVS     = 16,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  cfg_t              cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic              tick, tx_wr, pop;
  logic [2:0]        clr;
  logic              tx_empty, tx_end, rx_full, ovr, ferr, perr;
  logic [DATA_W-1:0] rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= DIV_RST;
    end else if (wr_en) begin
      if (addr == A_CTRL) cfg_q <= cfg_t'(wdata[5:0]);
      if (addr == A_DIV)  div_q <= DIV_W'(wdata);
    end
  end

  assign tx_wr = wr_en && (addr == A_DATA);
  assign pop   = rd_en && (addr == A_DATA);
  assign clr   = (wr_en && addr == A_STAT) ? wdata[5:3] : 3'b000;

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {2'b00, cfg_q};
      A_DIV:   rdata = 8'(div_q);
      A_DATA:  rdata = rx_data;
      default: rdata = {2'b00, perr, ferr, ovr, rx_full, tx_end, tx_empty};
    endcase
  end

  aport_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst_n(rst_n), .ext_sel(cfg_q.ext_clk), .pin_out(cfg_q.pin_out),
    .divisor(div_q), .sck_in(sck_in), .tick(tick), .sck_out(sck_out), .sck_oe(sck_oe)
  );

  aport_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(cfg_q.par_en),
    .par_odd(cfg_q.par_odd), .two_stop(cfg_q.two_stop), .len7(cfg_q.len7),
    .wr(tx_wr), .wdata(wdata), .txd(txd), .tx_empty(tx_empty), .tx_end(tx_end)
  );

  aport_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(cfg_q.par_en),
    .par_odd(cfg_q.par_odd), .len7(cfg_q.len7), .pop(pop), .clr(clr),
    .rx_data(rx_data), .rx_full(rx_full), .ovr(ovr), .ferr(ferr), .perr(perr)
  );

  // R7: with the external source chosen the clock pin is never driven
  p_pin_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.ext_clk |-> !sck_oe);
  // R11: a clear of the overrun bit without a new overrun leaves it low
  p_clear_ovr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && wdata[3] && !(u_rx.ovr_set)) |=> !ovr);
endmodule

// File: tb/async_port_test.sv
module async_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  logic       drv_rxd = 1'b1, loop_en = 1'b0, sck_in = 1'b0, ext_run = 1'b0;
  wire        txd, sck_out, sck_oe;
  wire        rxd = loop_en ? txd : drv_rxd;

  int cyc = 0;
  int nchk = 0, nfail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  async_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe)
  );

  // ctrl byte, data byte; ctrl: b5 7-bit, b4 two stop, b3 odd, b2 parity
  localparam logic [15:0] VECS [0:5] = '{
    16'h0055, 16'h04A3, 16'h0CA3, 16'h100F, 16'h24DA, 16'h3C81
  };

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int ones(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) if (d[i]) n++;
    return n;
  endfunction

  task automatic wait_fall();
    @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
  endtask

  task automatic wait_rise();
    while (txd !== 1'b1) @(negedge clk);
  endtask

  task automatic decode_tx(input int bt, input int nb, input bit pe, input int ns,
                           output logic [7:0] d, output bit p, output bit st_ok,
                           output bit sp_ok);
    d = 8'h00; p = 1'b0; sp_ok = 1'b1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bt / 2) @(negedge clk);
    st_ok = (txd == 1'b0);
    for (int i = 0; i < nb; i++) begin
      repeat (bt) @(negedge clk);
      d[i] = txd;
    end
    if (pe) begin
      repeat (bt) @(negedge clk);
      p = txd;
    end
    for (int s = 0; s < ns; s++) begin
      repeat (bt) @(negedge clk);
      if (txd !== 1'b1) sp_ok = 1'b0;
    end
  endtask

  task automatic drive_frame(input logic [7:0] d, input int nb, input bit pe,
                             input bit odd, input bit flip, input bit stop_low,
                             input int bt);
    logic [7:0] m;
    m = (nb == 7) ? (d & 8'h7F) : d;
    drv_rxd = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      drv_rxd = d[i];
      repeat (bt) @(negedge clk);
    end
    if (pe) begin
      drv_rxd = ((ones(m) % 2) == 1) ^ odd ^ flip;
      repeat (bt) @(negedge clk);
    end
    if (stop_low) begin
      drv_rxd = 1'b0;
      repeat (bt * 3 / 4) @(negedge clk);
    end
    drv_rxd = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic measure_high(output int n);
    n = 0;
    @(negedge clk);
    while (sck_out !== 1'b0) @(negedge clk);
    while (sck_out !== 1'b1) @(negedge clk);
    while (sck_out === 1'b1) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        c++;
        if (c == 4) begin
          c = 0;
          sck_in = ~sck_in;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] s, r, got, cfg, dv, exp_d, popped;
    bit         gp, st_ok, sp_ok, pe, odd;
    int         nb, ns, t0, t1, lat, t2, t3, hi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R1 idle txd after reset", txd, 1);
    reg_rd(2'd3, s);
    chk("R5 status after reset", s, 8'h03);
    chk("R6 pin undriven after reset", sck_oe, 0);
    reg_wr(2'd1, 8'd1);

    // table of frame formats, sent in loopback
    for (int i = 0; i < 6; i++) begin
      cfg = VECS[i][15:8];
      dv  = VECS[i][7:0];
      nb  = cfg[5] ? 7 : 8;
      pe  = cfg[2];
      odd = cfg[3];
      ns  = cfg[4] ? 2 : 1;
      exp_d = (nb == 7) ? (dv & 8'h7F) : dv;
      reg_wr(2'd0, cfg);
      loop_en = 1'b1;
      reg_wr(2'd2, dv);
      decode_tx(32, nb, pe, ns, got, gp, st_ok, sp_ok);
      chk("R2 start bit low", st_ok, 1);
      chk("R2 tx data bits", got, exp_d);
      if (pe) chk("R3 tx parity bit", gp, ((ones(exp_d) % 2) == 1) ^ odd);
      chk("R4 stop bits high", sp_ok, 1);
      repeat (48) @(negedge clk);
      reg_rd(2'd3, s);
      chk("R5 R9 status after loopback frame", s, 8'h07);
      reg_rd(2'd2, r);
      chk("R2 rx data", r, exp_d);
      reg_rd(2'd3, s);
      chk("R9 read clears full", s[2], 0);
    end
    loop_en = 1'b0;

    // false start
    reg_wr(2'd0, 8'h00);
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (8) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (400) @(negedge clk);
    reg_rd(2'd3, s);
    chk("R8 short low pulse rejected", s[2], 0);

    // parity error
    reg_wr(2'd0, 8'h04);
    @(negedge clk);
    drive_frame(8'h33, 8, 1'b1, 1'b0, 1'b1, 1'b0, 32);
    repeat (64) @(negedge clk);
    reg_rd(2'd3, s);
    chk("R10 parity error flagged", s, 8'h27);
    reg_rd(2'd2, r);
    chk("R10 byte kept on parity error", r, 8'h33);
    reg_wr(2'd3, 8'h38);
    reg_rd(2'd3, s);
    chk("R11 flags cleared", s, 8'h03);

    // framing error
    reg_wr(2'd0, 8'h00);
    @(negedge clk);
    drive_frame(8'h7E, 8, 1'b0, 1'b0, 1'b0, 1'b1, 32);
    repeat (64) @(negedge clk);
    reg_rd(2'd3, s);
    chk("R10 framing error flagged", s, 8'h17);
    reg_rd(2'd2, r);
    chk("R10 byte kept on framing error", r, 8'h7E);
    reg_wr(2'd3, 8'h10);
    reg_rd(2'd3, s);
    chk("R11 framing clear", s, 8'h03);

    // overrun
    @(negedge clk);
    drive_frame(8'h11, 8, 1'b0, 1'b0, 1'b0, 1'b0, 32);
    drive_frame(8'h22, 8, 1'b0, 1'b0, 1'b0, 1'b0, 32);
    repeat (64) @(negedge clk);
    reg_rd(2'd3, s);
    chk("R9 overrun flagged", s, 8'h0F);
    reg_rd(2'd2, r);
    chk("R9 old byte kept on overrun", r, 8'h11);
    reg_rd(2'd3, s);
    chk("R9 overrun sticky after read", s, 8'h0B);
    reg_wr(2'd3, 8'h08);
    reg_rd(2'd3, s);
    chk("R11 overrun clear", s, 8'h03);

    // back-to-back, 8 data, even parity, 2 stop
    reg_wr(2'd0, 8'h14);
    fork
      begin
        reg_wr(2'd2, 8'h00);
        reg_rd(2'd3, s);
        while (s[0] !== 1'b1) reg_rd(2'd3, s);
        reg_wr(2'd2, 8'h00);
        reg_rd(2'd3, s);
        chk("R5 flags while busy and pending", s[1:0], 2'b00);
        while (s[0] !== 1'b1) reg_rd(2'd3, s);
        reg_wr(2'd2, 8'h00);
      end
      begin
        wait_fall();
        wait_rise();
        while (txd !== 1'b0) @(negedge clk);
        t2 = cyc;
        wait_rise();
        while (txd !== 1'b0) @(negedge clk);
        t3 = cyc;
      end
    join
    chk("R4 no gap between characters", t3 - t2, 384);
    repeat (500) @(negedge clk);
    reg_rd(2'd3, s);
    chk("R5 transmit end after last frame", s[1:0], 2'b11);

    // pin clock output
    reg_wr(2'd0, 8'h01);
    @(negedge clk);
    chk("R6 pin driven", sck_oe, 1);
    measure_high(hi);
    chk("R6 pin high time div=1", hi, 16);
    reg_wr(2'd1, 8'd3);
    measure_high(hi);
    measure_high(hi);
    chk("R6 pin high time div=3", hi, 32);
    reg_wr(2'd1, 8'd1);
    reg_wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R6 pin released", sck_oe, 0);

    // external 16x clock
    ext_run = 1'b1;
    reg_wr(2'd0, 8'h03);
    @(negedge clk);
    chk("R7 pin is input in external mode", sck_oe, 0);
    loop_en = 1'b1;
    reg_wr(2'd2, 8'hC6);
    decode_tx(128, 8, 1'b0, 1, got, gp, st_ok, sp_ok);
    chk("R7 tx data on external clock", got, 8'hC6);
    repeat (200) @(negedge clk);
    reg_rd(2'd2, r);
    chk("R7 rx data on external clock", r, 8'hC6);
    loop_en = 1'b0;
    reg_wr(2'd0, 8'h00);
    ext_run = 1'b0;
    repeat (50) @(negedge clk);

    // pop colliding with a store
    addr = 2'd3;
    @(negedge clk);
    t0 = cyc;
    t1 = 0;
    fork
      drive_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 32);
      begin
        @(negedge clk);
        #1;
        while (rdata[2] !== 1'b1) begin
          @(negedge clk);
          #1;
        end
        t1 = cyc;
      end
    join
    lat = t1 - t0;
    repeat (20) @(negedge clk);
    while (((cyc - t0) % 2) != 0) @(negedge clk);
    t2 = cyc;
    fork
      drive_frame(8'hC5, 8, 1'b0, 1'b0, 1'b0, 1'b0, 32);
      begin
        while (cyc != t2 + lat - 1) @(negedge clk);
        addr = 2'd2; rd_en = 1'b1;
        #1 popped = rdata;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd3;
      end
    join
    repeat (20) @(negedge clk);
    chk("R12 colliding read returns old byte", popped, 8'h3C);
    reg_rd(2'd3, s);
    chk("R12 no overrun on collision", s, 8'h07);
    reg_rd(2'd2, r);
    chk("R12 new byte stored", r, 8'hC5);

    report();
    $finish;
  end
endmodule